// File: doc/BRIEF.md
# Linear Burst Read Controller

This block is the device-side control for a synchronous read port on a parallel memory. Straight out of reset it works asynchronously: the clock is ignored, and the data word follows the address pins combinationally whenever the chip is selected and output is enabled. Once a configuration word selects synchronous operation, the block latches a start address when an address-valid strobe arrives. It then steps an internal address up by one on each clock for a configured number of transfers. Alongside the data it drives an end-of-burst indicator.

The data and indicator pins are modelled as a value plus a drive enable, so a pad ring can build the tri-states. Deselecting the chip aborts a burst at once. A fresh address-valid strobe discards the running burst and starts a new one. Dropping output enable only floats the pins, and the burst keeps counting inside. A simple built-in array supplies the words: the word stored at address `a` is `a` zero-extended to the data width and XORed with a fixed pattern.

Top module: `lbrd_top`

## Requirements
- R1: After reset the block is in asynchronous mode. The clock and the address-valid strobe start no burst. `dataOe` is high exactly when `ceN` and `oeN` are both low. `dataOut` then equals `{8'h00, addrIn} ^ 16'hA5C3` combinationally.
- R2: The configuration register loads `cfgIn` on a rising clock edge with `cfgWe` high and `ceN` high. Its fields are: bit 0 = synchronous mode, bits 2:1 = `sel` (burst length is `2 << sel` transfers), and bits 5:3 = indicator code. A `cfgWe` pulse while `ceN` is low is ignored.
- R3: In synchronous mode, a rising edge with `ceN` and `advN` both low latches `addrIn` and leaves the bus floated. While `advN` stays low, later edges re-latch the address. The first edge with `advN` high presents the first transfer, which is the word at the latched address.
- R4: Each later rising edge (with `ceN` low and `advN` high) advances the word address by one, modulo 256, with no wrap at the burst boundary. After the configured number of transfers the bus floats and the block idles until a new start.
- R5: With `ceN` high, `dataOe` and `indOe` are low in the same cycle, without waiting for a clock edge. Any burst ends at the next edge. Taking `ceN` low again with `advN` high starts nothing.
- R6: `advN` low during a burst drops the running burst and latches the new address. Transfers resume at that new address once `advN` is high at an edge.
- R7: `oeN` high floats both the data bus and the indicator. The burst still advances internally, so re-enabling the output shows the address reached by then.
- R8: The indicator is driven exactly when data is driven in synchronous mode. It is high except during one transfer, when it is low. With code 3'b011 that transfer is the second-to-last one. With code 3'b001, or any other code, it is the last one.
- R9: `rstN` low acts at once, with no clock needed. It floats both outputs, ends any burst, and restores the default configuration: asynchronous mode, two transfers, indicator code 3'b001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Burst clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ceN | input | 1 | Chip enable, active low |
| advN | input | 1 | Address valid strobe, active low |
| oeN | input | 1 | Output enable, active low |
| addrIn | input | 8 | Word address |
| cfgWe | input | 1 | Configuration load strobe |
| cfgIn | input | 6 | Configuration word |
| dataOut | output | 16 | Data word (zero when not driven) |
| dataOe | output | 1 | Drive enable for the data bus |
| indOut | output | 1 | End-of-burst indicator level, active low |
| indOe | output | 1 | Drive enable for the indicator |

## Verification
The hardest states to reach are those where the internal burst has moved on while the pins show nothing. This happens with output enable high in the middle of a burst, and with address-valid held low across several edges. The bench holds `oeN` high for several beats of an eight-transfer burst and then compares the word that reappears with the advanced address. It also stretches `advN` over three edges and re-strobes it mid-burst with a different address. A reset is dropped into a running burst, and the bench then confirms asynchronous reads on the very next cycle.

// File: rtl/lbrd_pkg.sv
package lbrd_pkg;

  localparam int LEN_SEL_W = 2;
  localparam int BEAT_W    = LEN_SEL_W + 3;
  localparam int CFG_W     = 1 + LEN_SEL_W + 3;

  // Indicator code that moves the flag one transfer earlier.
  localparam logic [2:0] IND_EARLY = 3'b011;

  typedef struct packed {
    logic [2:0]           indCode;
    logic [LEN_SEL_W-1:0] lenSel;
    logic                 syncMode;
  } cfg_t;

  localparam cfg_t CFG_DEFAULT = '{indCode: 3'b001, lenSel: '0, syncMode: 1'b0};

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ARM  = 2'd1,
    PH_XFER = 2'd2
  } phase_t;

  typedef struct packed {
    logic loadAddr;
    logic stepAddr;
    logic syncMode;
    logic busEn;
  } strobe_t;

  function automatic logic [BEAT_W-1:0] beatsOf(input logic [LEN_SEL_W-1:0] sel);
    return BEAT_W'(2) << sel;
  endfunction

endpackage

// File: rtl/lbrd_ctrl.sv
module lbrd_ctrl
  import lbrd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceN,
  input  logic             advN,
  input  logic             oeN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgIn,
  output strobe_t          strobes,
  output logic             indOut,
  output logic             indOe
);

  cfg_t              cfgQ;
  phase_t            phase, phaseNext;
  logic [BEAT_W-1:0] beat, beatNext;
  logic [BEAT_W-1:0] lenBeats;
  logic [BEAT_W-1:0] flagBeat;
  logic              lastBeat;
  logic              loadAddr, stepAddr;
  logic              inXfer;

  assign lenBeats = beatsOf(cfgQ.lenSel);
  assign lastBeat = (beat == lenBeats - BEAT_W'(1));
  assign inXfer   = (phase == PH_XFER);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ  <= CFG_DEFAULT;
      phase <= PH_IDLE;
      beat  <= '0;
    end else begin
      if (cfgWe && ceN) begin
        cfgQ <= cfg_t'(cfgIn);
      end
      phase <= phaseNext;
      beat  <= beatNext;
    end
  end

  always_comb begin
    phaseNext = phase;
    beatNext  = beat;
    loadAddr  = 1'b0;
    stepAddr  = 1'b0;
    if (!cfgQ.syncMode || ceN) begin
      phaseNext = PH_IDLE;
    end else if (!advN) begin
      phaseNext = PH_ARM;
      beatNext  = '0;
      loadAddr  = 1'b1;
    end else begin
      unique case (phase)
        PH_ARM: begin
          phaseNext = PH_XFER;
          beatNext  = '0;
        end
        PH_XFER: begin
          if (lastBeat) begin
            phaseNext = PH_IDLE;
          end else begin
            beatNext = beat + BEAT_W'(1);
            stepAddr = 1'b1;
          end
        end
        default: phaseNext = PH_IDLE;
      endcase
    end
  end

  // Output drive follows the pins combinationally so a deselect floats at once.
  logic pinsOn;
  assign pinsOn = rstN && !ceN && !oeN;

  assign strobes.loadAddr = loadAddr;
  assign strobes.stepAddr = stepAddr;
  assign strobes.syncMode = cfgQ.syncMode;
  assign strobes.busEn    = pinsOn && (cfgQ.syncMode ? inXfer : 1'b1);

  assign flagBeat = (cfgQ.indCode == IND_EARLY) ? lenBeats - BEAT_W'(2)
                                               : lenBeats - BEAT_W'(1);
  assign indOe    = pinsOn && cfgQ.syncMode && inXfer;
  assign indOut   = indOe ? (beat != flagBeat) : 1'b1;

endmodule

// File: rtl/lbrd_dpath.sv
module lbrd_dpath
  import lbrd_pkg::*;
#(
  parameter int              ADDR_W  = 8,
  parameter int              DATA_W  = 16,
  parameter logic [DATA_W-1:0] PATTERN = 16'hA5C3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  strobe_t           strobes,
  output logic [DATA_W-1:0] dataOut
);

  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] selAddr;
  logic [DATA_W-1:0] extAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
    end else if (strobes.loadAddr) begin
      addrReg <= addrIn;
    end else if (strobes.stepAddr) begin
      addrReg <= addrReg + ADDR_W'(1);
    end
  end

  assign selAddr = strobes.syncMode ? addrReg : addrIn;

  // Array contents: address fitted to the data width, then patterned.
  generate
    if (DATA_W >= ADDR_W) begin : g_widen
      localparam int PAD = DATA_W - ADDR_W;
      if (PAD > 0) begin : g_pad
        assign extAddr = {{PAD{1'b0}}, selAddr};
      end else begin : g_same
        assign extAddr = selAddr;
      end
    end else begin : g_trunc
      assign extAddr = selAddr[DATA_W-1:0];
    end
  endgenerate

  assign dataOut = strobes.busEn ? (extAddr ^ PATTERN) : '0;

endmodule

// File: rtl/lbrd_top.sv
module lbrd_top
  import lbrd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              advN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              cfgWe,
  input  logic [CFG_W-1:0]  cfgIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              indOut,
  output logic              indOe
);

  strobe_t strobes;

  lbrd_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .ceN     (ceN),
    .advN    (advN),
    .oeN     (oeN),
    .cfgWe   (cfgWe),
    .cfgIn   (cfgIn),
    .strobes (strobes),
    .indOut  (indOut),
    .indOe   (indOe)
  );

  lbrd_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .addrIn  (addrIn),
    .strobes (strobes),
    .dataOut (dataOut)
  );

  assign dataOe = strobes.busEn;

endmodule

// File: rtl/lbrd_chk.sv
module lbrd_chk (
  input logic clk,
  input logic rstN,
  input logic ceN,
  input logic oeN,
  input logic syncMode,
  input logic dataOe,
  input logic indOut,
  input logic indOe
);

  // R9: reset floats both outputs without waiting for a clock
  always_comb begin
    if (!rstN) begin
      a_rst_float_r9: assert (!dataOe && !indOe);
    end
  end

  p_ce_float_r5: assert property (@(posedge clk) disable iff (!rstN)
    ceN |-> (!dataOe && !indOe));

  p_oe_float_r7: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> (!dataOe && !indOe));

  p_async_drive_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!syncMode && !ceN && !oeN) |-> dataOe);

  p_ind_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    (indOe && !indOut) |=> (!indOe || indOut));

  p_ind_with_data_r8: assert property (@(posedge clk) disable iff (!rstN)
    indOe |-> dataOe);

endmodule

bind lbrd_top lbrd_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .ceN      (ceN),
  .oeN      (oeN),
  .syncMode (strobes.syncMode),
  .dataOe   (dataOe),
  .indOut   (indOut),
  .indOe    (indOe)
);

// File: tb/lbrd_top_tb_top.sv
`timescale 1ns/1ps
module lbrd_top_tb_top;

  localparam int HALF = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceN = 1'b1;
  logic        advN = 1'b1;
  logic        oeN = 1'b1;
  logic [7:0]  addrIn = '0;
  logic        cfgWe = 1'b0;
  logic [5:0]  cfgIn = '0;
  logic [15:0] dataOut;
  logic        dataOe;
  logic        indOut;
  logic        indOe;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model state
  int mSync, mLenSel, mCode, mPhase, mAddr, mBeat;

  always #HALF clk = ~clk;

  lbrd_top dut_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .advN(advN), .oeN(oeN),
    .addrIn(addrIn), .cfgWe(cfgWe), .cfgIn(cfgIn),
    .dataOut(dataOut), .dataOe(dataOe), .indOut(indOut), .indOe(indOe)
  );

  function automatic int wordAt(input int a);
    return (a & 255) ^ 16'hA5C3;
  endfunction

  task automatic modelReset();
    mSync = 0; mLenSel = 0; mCode = 1; mPhase = 0; mAddr = 0; mBeat = 0;
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareOutputs(input string tag);
    int len, flag;
    bit expOe, expIndOe;
    len = 2 << mLenSel;
    flag = (mCode == 3) ? len - 2 : len - 1;
    if (!rstN) begin
      expOe = 0; expIndOe = 0;
    end else if (mSync != 0) begin
      expOe = (mPhase == 2) && !ceN && !oeN;
      expIndOe = expOe;
    end else begin
      expOe = !ceN && !oeN;
      expIndOe = 0;
    end
    chk(tag, "dataOe", int'(dataOe), int'(expOe));
    if (expOe) chk(tag, "dataOut", int'(dataOut), wordAt(mSync != 0 ? mAddr : int'(addrIn)));
    chk(tag, "indOe", int'(indOe), int'(expIndOe));
    if (expIndOe) chk(tag, "indOut", int'(indOut), (mBeat == flag) ? 0 : 1);
  endtask

  task automatic modelEdge();
    int len;
    int oldSync;
    if (!rstN) begin
      modelReset();
      return;
    end
    len = 2 << mLenSel;
    oldSync = mSync;
    if (oldSync == 0 || ceN) begin
      mPhase = 0;
    end else if (!advN) begin
      mPhase = 1; mAddr = int'(addrIn); mBeat = 0;
    end else if (mPhase == 1) begin
      mPhase = 2; mBeat = 0;
    end else if (mPhase == 2) begin
      if (mBeat == len - 1) mPhase = 0;
      else begin
        mBeat++;
        mAddr = (mAddr + 1) & 255;
      end
    end
    if (cfgWe && ceN) begin
      mSync = cfgIn[0]; mLenSel = int'(cfgIn[2:1]); mCode = int'(cfgIn[5:3]);
    end
  endtask

  // One clock: drive after falling edge, compare mid-low phase, advance model at rising edge.
  task automatic cyc(input string tag, input bit ce, input bit adv, input bit oe, input int a);
    ceN = ce; advN = adv; oeN = oe; addrIn = 8'(a);
    #(HALF / 2);
    compareOutputs(tag);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic writeCfg(input string tag, input bit [5:0] val);
    cfgWe = 1'b1; cfgIn = val;
    cyc(tag, 1, 1, 1, 0);
  endtask

  task automatic runIdle(input string tag, input int n, input bit oe);
    for (int i = 0; i < n; i++) cyc(tag, 0, 1, oe, 8'hEE);
  endtask

  initial begin
    #(HALF * 2 * 100000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    modelReset();
    @(negedge clk);
    // R9: reset state, outputs floated even with pins active
    rstN = 1'b0;
    cyc("R9", 0, 0, 0, 8'h11);
    cyc("R9", 1, 1, 1, 8'h11);
    rstN = 1'b1;

    // R1: asynchronous reads, clock and address strobe start nothing
    cyc("R1", 0, 1, 0, 8'h12);
    cyc("R1", 0, 1, 0, 8'h34);
    cyc("R1", 0, 0, 0, 8'h40);
    cyc("R1", 0, 1, 0, 8'hFF);
    cyc("R1", 0, 1, 1, 8'h56);
    cyc("R1", 1, 1, 0, 8'h56);

    // R2: write ignored while selected -> still async
    cfgWe = 1'b1; cfgIn = 6'b001_01_1;
    cyc("R2", 0, 1, 0, 8'h21);
    cyc("R2", 0, 1, 0, 8'h22);
    // R2: sync, four transfers, flag on last
    writeCfg("R2", 6'b001_01_1);

    // R3 R4 R8: burst from 0x20
    cyc("R3", 0, 0, 0, 8'h20);
    runIdle("R4", 6, 0);
    // R3: address-valid held low across edges
    cyc("R3", 0, 0, 0, 8'h50);
    cyc("R3", 0, 0, 0, 8'h60);
    cyc("R3", 0, 0, 0, 8'h70);
    runIdle("R3", 6, 0);

    // R8: eight transfers, flag on second-to-last
    writeCfg("R8", 6'b011_10_1);
    cyc("R8", 0, 0, 0, 8'h80);
    runIdle("R8", 10, 0);

    // R7: output float mid-burst, internal advance continues
    cyc("R7", 0, 0, 0, 8'h90);
    runIdle("R7", 2, 0);
    runIdle("R7", 3, 1);
    runIdle("R7", 5, 0);

    // R5: deselect aborts, reselect without strobe starts nothing
    cyc("R5", 0, 0, 0, 8'hA0);
    runIdle("R5", 3, 0);
    cyc("R5", 1, 1, 0, 8'hA0);
    runIdle("R5", 3, 0);
    cyc("R5", 0, 0, 0, 8'hA8);
    runIdle("R5", 4, 0);

    // R6: restart mid-burst at a new address
    cyc("R6", 0, 0, 0, 8'hB0);
    runIdle("R6", 3, 0);
    cyc("R6", 0, 0, 0, 8'hC4);
    runIdle("R6", 10, 0);

    // R4: sixteen transfers crossing the top of the address range
    writeCfg("R4", 6'b001_11_1);
    cyc("R4", 0, 0, 0, 8'hF8);
    runIdle("R4", 19, 0);

    // R8: unlisted code behaves as last-transfer flag, two transfers
    writeCfg("R8", 6'b110_00_1);
    cyc("R8", 0, 0, 0, 8'h05);
    runIdle("R8", 4, 0);
    // R8: second-to-last with two transfers flags the first
    writeCfg("R8", 6'b011_00_1);
    cyc("R8", 0, 0, 0, 8'h07);
    runIdle("R8", 4, 0);

    // R9: reset mid-burst, then async reads with default config
    writeCfg("R9", 6'b001_10_1);
    cyc("R9", 0, 0, 0, 8'h30);
    runIdle("R9", 2, 0);
    rstN = 1'b0;
    cyc("R9", 0, 1, 0, 8'h33);
    rstN = 1'b1;
    cyc("R9", 0, 1, 0, 8'h33);
    cyc("R9", 0, 0, 0, 8'h34);
    runIdle("R9", 3, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule